// File: doc/BRIEF.md
# Indirect SerDes Control-Register Access Sequencer

This block gives on-chip logic single-command access to the control registers of a SerDes. Those registers are not directly mapped. They sit behind three indirect registers: a control register, an address register and a data register. The block can reach those three only through a narrow window on a simple memory-mapped bus.

Every touch of an indirect register takes two bus accesses. The first writes a page-select word to a fixed window slot. The second performs the real read or write at a byte offset inside the window.

A client places a device number, a 16-bit SerDes register address, a write flag and write data on the command port. The block then runs the whole handshake on its own. It polls the busy flag before the operation, and it also polls after the operation when the command is a read. Reads return their data on the response port.

Between busy polls the block waits a programmable number of idle cycles. If the busy flag does not clear within a fixed number of polls, the command is aborted and its response is marked as timed out.

Top module: `serdes_cr_master`

## Requirements
- R1: Before every window access the block writes a page-select word to bus byte offset 0x800. In that word, bits [11:7] carry the command's 5-bit device number, bits [6:0] carry bits [15:9] of the indirect register's SerDes address, and all other bits are zero.
- R2: A window access uses bus byte offset {addr[8:0], 2'b00} for SerDes address addr. The indirect registers are at SerDes addresses 0x80A0 (control), 0x80A1 (address) and 0x80A2 (data).
- R3: A read command runs five steps in order:
  1. Poll control until it is not busy.
  2. Write the command address to the address register.
  3. Write 0x0001 to control (start, with the write bit clear).
  4. Poll control until it is not busy.
  5. Read the data register.
  
  The low 16 bits of that read are returned on rsp_data.
- R4: A write command runs four steps in order:
  1. Poll control until it is not busy.
  2. Write the address register.
  3. Write the data register.
  4. Write 0x0003 to control (start plus write bit 1).
  
  It does not poll afterwards, so the response may appear while the SerDes is still busy. rsp_data is 0 for writes.
- R5: Busy is bit 0 of a control-register read. Polling repeats while busy is set. After a busy result, at least cfg_poll_gap idle cycles pass before the next poll.
- R6: If POLL_LIMIT consecutive polls within one wait all read busy, the command is abandoned. The block issues a response with rsp_timeout = 1 and rsp_data = 0, and makes no further bus accesses for that command. The next command then runs normally.
- R7: A command is taken when cmd_valid and cmd_ready are both high. cmd_ready stays low from then until the response. Each command produces exactly one single-cycle rsp_valid pulse. rsp_timeout is high only together with rsp_valid.
- R8: Once bus_req is raised, it stays high with stable bus_we, bus_addr and bus_wdata until the cycle in which bus_ack is seen.
- R9: After reset, cmd_ready is 1 while bus_req and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_dev | input | 5 | Target SerDes device number |
| cmd_addr | input | 16 | SerDes control-register address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 16 | Write data |
| cfg_poll_gap | input | 8 | Idle cycles between busy polls |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read data (0 for writes and timeouts) |
| rsp_timeout | output | 1 | Command aborted on busy timeout |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 12 | Bus byte offset |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Bus access complete |

## Verification
Several properties are checked on every cycle:
- the bus request holds steady until it is acknowledged;
- page-select accesses are always writes, and window offsets are word aligned;
- the bus stays quiet while the block is idle;
- the response is a single pulse, and a timeout can only appear alongside one;
- the command port closes after acceptance.

Other behaviour can only be shown by the bench's SerDes model, because it depends on the meaning of the traffic:
- the order of the indirect steps for reads and writes;
- the device field and address decode of each page word;
- that no write is issued while busy and no poll follows a write;
- the spacing of polls;
- the exact number of polls before a timeout;
- that read data comes back intact.

// File: rtl/cr_pkg.sv
`timescale 1ns/1ps
package cr_pkg;
    localparam int DEV_W   = 5;
    localparam int REG_W   = 16;
    localparam int VAL_W   = 16;
    localparam int BUS_AW  = 12;
    localparam int BUS_DW  = 32;
    localparam int WIN_W   = 9;
    localparam int PAGE_W  = REG_W - WIN_W;

    localparam logic [BUS_AW-1:0] PAGE_SEL_OFF = 12'h800;
    localparam logic [REG_W-1:0]  IND_CTL = 16'h80A0;
    localparam logic [REG_W-1:0]  IND_ADR = 16'h80A1;
    localparam logic [REG_W-1:0]  IND_DAT = 16'h80A2;
    localparam int CTL_BUSY_BIT  = 0;
    localparam int CTL_START_BIT = 0;
    localparam int CTL_WRITE_BIT = 1;

    typedef enum logic [1:0] {SEL_CTL, SEL_ADR, SEL_DAT} ind_sel_e;

    typedef struct packed {
        logic             we;
        ind_sel_e         sel;
        logic [VAL_W-1:0] wdata;
    } win_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_POLL, S_PRE_GAP, S_SET_ADR, S_SET_DAT,
        S_GO, S_POST_POLL, S_POST_GAP, S_GET, S_RESP
    } seq_state_e;

    function automatic logic [REG_W-1:0] ind_reg(ind_sel_e s);
        case (s)
            SEL_ADR: ind_reg = IND_ADR;
            SEL_DAT: ind_reg = IND_DAT;
            default: ind_reg = IND_CTL;
        endcase
    endfunction

    function automatic logic [BUS_DW-1:0] page_word(logic [DEV_W-1:0] dev,
                                                    logic [REG_W-1:0] a);
        page_word = '0;
        page_word[PAGE_W +: DEV_W] = dev;
        page_word[PAGE_W-1:0]      = a[REG_W-1:WIN_W];
    endfunction

    function automatic logic [BUS_AW-1:0] window_off(logic [REG_W-1:0] a);
        window_off = '0;
        window_off[WIN_W+1:2] = a[WIN_W-1:0];
    endfunction
endpackage

// File: rtl/cr_gap_timer.sv
`timescale 1ns/1ps
module cr_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cr_win_port.sv
`timescale 1ns/1ps
module cr_win_port import cr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  win_op_t           op,
    input  logic [DEV_W-1:0]  op_dev,
    output logic              op_done,
    output logic [VAL_W-1:0]  op_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_DW-1:0] bus_rdata,
    input  logic              bus_ack
);
    typedef enum logic [1:0] {WP_IDLE, WP_PAGE, WP_WIN} wp_state_e;

    wp_state_e        st;
    win_op_t          op_q;
    logic [DEV_W-1:0] dev_q;
    logic [REG_W-1:0] tgt;
    logic             unused_rdata_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= WP_IDLE;
            op_q  <= '0;
            dev_q <= '0;
        end else begin
            case (st)
                WP_IDLE: if (op_start) begin
                    op_q  <= op;
                    dev_q <= op_dev;
                    st    <= WP_PAGE;
                end
                WP_PAGE: if (bus_ack) st <= WP_WIN;
                WP_WIN:  if (bus_ack) st <= WP_IDLE;
                default: st <= WP_IDLE;
            endcase
        end
    end

    assign tgt = ind_reg(op_q.sel);

    always_comb begin
        bus_req   = (st != WP_IDLE);
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        if (st == WP_PAGE) begin
            bus_we    = 1'b1;
            bus_addr  = PAGE_SEL_OFF;
            bus_wdata = page_word(dev_q, tgt);
        end else if (st == WP_WIN) begin
            bus_we    = op_q.we;
            bus_addr  = window_off(tgt);
            bus_wdata = BUS_DW'(op_q.wdata);
        end
    end

    assign op_done         = (st == WP_WIN) && bus_ack;
    assign op_rdata        = bus_rdata[VAL_W-1:0];
    assign unused_rdata_hi = ^bus_rdata[BUS_DW-1:VAL_W];
endmodule

// File: rtl/cr_sequencer.sv
`timescale 1ns/1ps
module cr_sequencer import cr_pkg::*; #(
    parameter int POLL_LIMIT = 16,
    parameter int GAP_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [DEV_W-1:0] cmd_dev,
    input  logic [REG_W-1:0] cmd_addr,
    input  logic             cmd_write,
    input  logic [VAL_W-1:0] cmd_wdata,
    input  logic [GAP_W-1:0] cfg_poll_gap,
    output logic             rsp_valid,
    output logic [VAL_W-1:0] rsp_data,
    output logic             rsp_timeout,
    output logic             op_start,
    output win_op_t          op,
    output logic [DEV_W-1:0] op_dev,
    input  logic             op_done,
    input  logic [VAL_W-1:0] op_rdata,
    output logic             gap_load,
    output logic [GAP_W-1:0] gap_val,
    input  logic             gap_expired
);
    localparam int PC_W = $clog2(POLL_LIMIT + 1);

    seq_state_e       st;
    logic             inflight;
    logic [REG_W-1:0] addr_q;
    logic             wr_q;
    logic [VAL_W-1:0] wd_q;
    logic [PC_W-1:0]  polls;
    logic             to_q;
    logic             issue;
    logic             in_poll;
    logic             busy_seen;
    logic             poll_last;
    logic [VAL_W-1:0] ctl_word;

    always_comb begin
        ctl_word = '0;
        ctl_word[CTL_START_BIT] = 1'b1;
        ctl_word[CTL_WRITE_BIT] = wr_q;
    end

    always_comb begin
        issue    = 1'b1;
        op.we    = 1'b0;
        op.sel   = SEL_CTL;
        op.wdata = '0;
        case (st)
            S_PRE_POLL, S_POST_POLL: op.sel = SEL_CTL;
            S_SET_ADR: begin op.we = 1'b1; op.sel = SEL_ADR; op.wdata = VAL_W'(addr_q); end
            S_SET_DAT: begin op.we = 1'b1; op.sel = SEL_DAT; op.wdata = wd_q; end
            S_GO:      begin op.we = 1'b1; op.sel = SEL_CTL; op.wdata = ctl_word; end
            S_GET:     op.sel = SEL_DAT;
            default:   issue = 1'b0;
        endcase
    end

    assign op_start  = issue && !inflight;
    assign in_poll   = (st == S_PRE_POLL) || (st == S_POST_POLL);
    assign busy_seen = op_rdata[CTL_BUSY_BIT];
    assign poll_last = (polls == PC_W'(POLL_LIMIT - 1));
    assign gap_load  = op_done && in_poll && busy_seen && !poll_last;
    assign gap_val   = cfg_poll_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            inflight <= 1'b0;
            op_dev   <= '0;
            addr_q   <= '0;
            wr_q     <= 1'b0;
            wd_q     <= '0;
            polls    <= '0;
            to_q     <= 1'b0;
            rsp_data <= '0;
        end else begin
            if (op_start) inflight <= 1'b1;
            if (op_done)  inflight <= 1'b0;
            case (st)
                S_IDLE: if (cmd_valid) begin
                    op_dev <= cmd_dev;
                    addr_q <= cmd_addr;
                    wr_q   <= cmd_write;
                    wd_q   <= cmd_wdata;
                    polls  <= '0;
                    to_q   <= 1'b0;
                    st     <= S_PRE_POLL;
                end
                S_PRE_POLL, S_POST_POLL: if (op_done) begin
                    if (!busy_seen) begin
                        polls <= '0;
                        st    <= (st == S_PRE_POLL) ? S_SET_ADR : S_GET;
                    end else if (poll_last) begin
                        to_q     <= 1'b1;
                        rsp_data <= '0;
                        st       <= S_RESP;
                    end else begin
                        polls <= polls + 1'b1;
                        st    <= (st == S_PRE_POLL) ? S_PRE_GAP : S_POST_GAP;
                    end
                end
                S_PRE_GAP:  if (gap_expired) st <= S_PRE_POLL;
                S_POST_GAP: if (gap_expired) st <= S_POST_POLL;
                S_SET_ADR:  if (op_done) st <= wr_q ? S_SET_DAT : S_GO;
                S_SET_DAT:  if (op_done) st <= S_GO;
                S_GO: if (op_done) begin
                    if (wr_q) begin
                        rsp_data <= '0;
                        st       <= S_RESP;
                    end else begin
                        st <= S_POST_POLL;
                    end
                end
                S_GET: if (op_done) begin
                    rsp_data <= op_rdata;
                    st       <= S_RESP;
                end
                S_RESP:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign cmd_ready   = (st == S_IDLE);
    assign rsp_valid   = (st == S_RESP);
    assign rsp_timeout = (st == S_RESP) && to_q;
endmodule

// File: rtl/serdes_cr_master.sv
`timescale 1ns/1ps
module serdes_cr_master import cr_pkg::*; #(
    parameter int POLL_LIMIT = 16,
    parameter int GAP_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [REG_W-1:0]  cmd_addr,
    input  logic              cmd_write,
    input  logic [VAL_W-1:0]  cmd_wdata,
    input  logic [GAP_W-1:0]  cfg_poll_gap,
    output logic              rsp_valid,
    output logic [VAL_W-1:0]  rsp_data,
    output logic              rsp_timeout,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_DW-1:0] bus_rdata,
    input  logic              bus_ack
);
    logic             op_start;
    win_op_t          op;
    logic [DEV_W-1:0] op_dev;
    logic             op_done;
    logic [VAL_W-1:0] op_rdata;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_expired;

    cr_sequencer #(.POLL_LIMIT(POLL_LIMIT), .GAP_W(GAP_W)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dev(cmd_dev), .cmd_addr(cmd_addr),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .cfg_poll_gap(cfg_poll_gap),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
        .op_start(op_start), .op(op), .op_dev(op_dev),
        .op_done(op_done), .op_rdata(op_rdata),
        .gap_load(gap_load), .gap_val(gap_val), .gap_expired(gap_expired)
    );

    cr_win_port u_win (
        .clk(clk), .rst(rst),
        .op_start(op_start), .op(op), .op_dev(op_dev),
        .op_done(op_done), .op_rdata(op_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    cr_gap_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst),
        .load(gap_load), .load_val(gap_val), .expired(gap_expired)
    );
endmodule

// File: rtl/cr_master_checks.sv
`timescale 1ns/1ps
module cr_master_checks import cr_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_timeout,
    input logic              bus_req,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              bus_ack
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R8

    AST_PAGE_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr == PAGE_SEL_OFF) |-> (bus_we && bus_wdata[BUS_DW-1:PAGE_W+DEV_W] == '0)); // R1

    AST_WIN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr != PAGE_SEL_OFF) |-> (bus_addr[1:0] == 2'b00 && !bus_addr[BUS_AW-1])); // R2

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R7

    AST_TIMEOUT_QUAL: assert property (@(posedge clk) disable iff (rst)
        rsp_timeout |-> rsp_valid); // R6

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !bus_req); // R9
endmodule

bind serdes_cr_master cr_master_checks u_checks (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/serdes_cr_master_test.sv
`timescale 1ns/1ps
module serdes_cr_master_test;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [4:0]  cmd_dev = '0;
    logic [15:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  cfg_poll_gap = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rsp_timeout;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #2 clk = ~clk;

    serdes_cr_master #(.POLL_LIMIT(LIMIT), .GAP_W(8)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dev(cmd_dev), .cmd_addr(cmd_addr),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .cfg_poll_gap(cfg_poll_gap),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // SerDes model state
    logic [15:0] mem [int];
    logic [15:0] shadow [int];
    logic [15:0] page = '0;
    bit          page_fresh = 0;
    logic [15:0] m_adr = '0, m_dat = '0, last_ctl = '0, full_a;
    bit          adr_fresh = 0, dat_fresh = 0, m_busy, stuck = 0, prev_busy = 0;
    int          busy_cnt = 0, busy_len = 0, gap_cfg = 0, cyc = 0, prev_cyc = 0;
    int          v_page = 0, v_dec = 0, v_ord = 0, v_gap = 0, v_hold = 0;
    int          ctl_reads = 0, after_start = 0, adr_writes = 0;
    logic [4:0]  exp_dev = '0;
    logic [11:0] h_addr;
    logic [31:0] h_wd;
    logic        h_we;

    function automatic logic [15:0] seed_val(logic [15:0] a);
        return (a * 16'd37) ^ 16'hC35A;
    endfunction
    function automatic logic [15:0] rd_mem(logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : seed_val(a);
    endfunction
    function automatic logic [15:0] rd_shadow(logic [15:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : seed_val(a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            cyc = cyc + 1;
            m_busy = stuck || (busy_cnt > 0);
            if (bus_ack && (!bus_req || bus_addr != h_addr || bus_we != h_we || bus_wdata != h_wd))
                v_hold = v_hold + 1;
            if (bus_req && !bus_ack) begin
                bus_ack   <= 1'b1;
                bus_rdata <= '0;
                h_addr = bus_addr; h_we = bus_we; h_wd = bus_wdata;
                if (bus_addr == 12'h800) begin
                    if (!bus_we || bus_wdata[11:7] != exp_dev || bus_wdata[31:12] != 0)
                        v_page = v_page + 1;
                    page = bus_wdata[15:0];
                    page_fresh = 1;
                end else begin
                    if (!page_fresh) v_page = v_page + 1;
                    page_fresh = 0;
                    if (bus_addr[1:0] != 0 || bus_addr[11]) v_dec = v_dec + 1;
                    full_a = {page[6:0], bus_addr[10:2]};
                    case (full_a)
                        16'h80A0: begin
                            if (bus_we) begin
                                last_ctl = bus_wdata[15:0];
                                if (m_busy) v_ord = v_ord + 1;
                                if (bus_wdata[0]) begin
                                    if (!adr_fresh) v_ord = v_ord + 1;
                                    if (bus_wdata[1]) begin
                                        if (!dat_fresh) v_ord = v_ord + 1;
                                        mem[int'(m_adr)] = m_dat;
                                    end else begin
                                        m_dat = rd_mem(m_adr);
                                    end
                                    adr_fresh = 0; dat_fresh = 0;
                                    busy_cnt = busy_len;
                                    after_start = 0;
                                end
                            end else begin
                                ctl_reads = ctl_reads + 1;
                                after_start = after_start + 1;
                                if (prev_busy && (cyc - prev_cyc) <= gap_cfg) v_gap = v_gap + 1;
                                prev_busy = m_busy;
                                prev_cyc = cyc;
                                bus_rdata <= {31'b0, m_busy};
                            end
                        end
                        16'h80A1: begin
                            if (!bus_we) v_dec = v_dec + 1;
                            else begin
                                if (m_busy) v_ord = v_ord + 1;
                                m_adr = bus_wdata[15:0];
                                adr_fresh = 1; dat_fresh = 0;
                                adr_writes = adr_writes + 1;
                            end
                        end
                        16'h80A2: begin
                            if (m_busy) v_ord = v_ord + 1;
                            if (bus_we) begin
                                m_dat = bus_wdata[15:0];
                                if (!adr_fresh) v_ord = v_ord + 1;
                                dat_fresh = 1;
                            end else begin
                                bus_rdata <= {16'b0, m_dat};
                            end
                        end
                        default: v_dec = v_dec + 1;
                    endcase
                end
            end else begin
                bus_ack <= 1'b0;
            end
            if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [15:0] r_data;
    bit          r_to, r_got, r_busy, r_rdy_after;

    task automatic do_cmd(input logic [4:0] d, input logic [15:0] a,
                          input logic w, input logic [15:0] wd);
        int n;
        @(negedge clk);
        exp_dev = d; prev_busy = 0;
        ctl_reads = 0; adr_writes = 0;
        cmd_dev = d; cmd_addr = a; cmd_write = w; cmd_wdata = wd; cmd_valid = 1'b1;
        n = 0;
        while (!cmd_ready && n < 1000) begin @(negedge clk); n++; end
        @(negedge clk);
        cmd_valid = 1'b0;
        r_rdy_after = cmd_ready;
        r_got = 0; r_data = '0; r_to = 0; r_busy = 0; n = 0;
        while (!r_got && n < 5000) begin
            if (rsp_valid) begin
                r_got = 1; r_data = rsp_data; r_to = rsp_timeout;
                r_busy = stuck || (busy_cnt > 0);
            end else begin
                @(negedge clk); n++;
            end
        end
    endtask

    task automatic run(input logic [4:0] d, input logic [15:0] a, input logic w,
                       input logic [15:0] wd, input int bl, input int gap, input bit exp_to);
        int p0, d0, o0, g0, h0;
        busy_len = bl; gap_cfg = gap; cfg_poll_gap = 8'(gap);
        p0 = v_page; d0 = v_dec; o0 = v_ord; g0 = v_gap; h0 = v_hold;
        do_cmd(d, a, w, wd);
        chk(r_got, "R7", "response seen", int'(r_got), 1);
        chk(!r_rdy_after, "R7", "ready low after accept", int'(r_rdy_after), 0);
        if (exp_to) begin
            chk(r_to, "R6", "timeout flag", int'(r_to), 1);
            chk(ctl_reads == LIMIT, "R6", "poll count", ctl_reads, LIMIT);
            chk(adr_writes == 0, "R6", "no access after abort", adr_writes, 0);
            chk(r_data == 0, "R6", "data on timeout", int'(r_data), 0);
        end else begin
            chk(!r_to, "R7", "no timeout", int'(r_to), 0);
            if (w) begin
                shadow[int'(a)] = wd;
                chk(last_ctl == 16'h0003, "R4", "start word", int'(last_ctl), 3);
                chk(after_start == 0, "R4", "no post poll", after_start, 0);
                chk(r_data == 0, "R4", "write rsp data", int'(r_data), 0);
            end else begin
                chk(r_data == rd_shadow(a), "R3", "read data", int'(r_data), int'(rd_shadow(a)));
                chk(last_ctl == 16'h0001, "R3", "start word", int'(last_ctl), 1);
                chk(after_start >= 1, "R3", "post poll", after_start, 1);
            end
        end
        chk(v_page == p0, "R1", "page select", v_page - p0, 0);
        chk(v_dec == d0, "R2", "window decode", v_dec - d0, 0);
        chk(v_ord == o0, "R3", "step order/busy", v_ord - o0, 0);
        chk(v_gap == g0, "R5", "poll spacing", v_gap - g0, 0);
        chk(v_hold == h0, "R8", "request hold", v_hold - h0, 0);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R9", "reset ready", int'(cmd_ready), 1);
        chk(bus_req == 1'b0, "R9", "reset bus idle", int'(bus_req), 0);
        chk(rsp_valid == 1'b0, "R9", "reset rsp", int'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && bus_req == 1'b0, "R9", "idle after reset", int'(bus_req), 0);

        // directed corners
        run(5'd0,  16'h0000, 1'b0, 16'h0, 0, 0, 0);         // R3 read, device 0
        run(5'd31, 16'hFFFF, 1'b1, 16'hBEEF, 2, 1, 0);     // R4 write, max device/address
        run(5'd31, 16'hFFFF, 1'b0, 16'h0, 3, 1, 0);         // R3 read back
        run(5'd9,  16'h1234, 1'b1, 16'h0F0F, 40, 4, 0);     // R4 response while busy
        chk(r_busy, "R4", "response while still busy", int'(r_busy), 1);
        run(5'd9,  16'h1234, 1'b0, 16'h0, 60, 20, 0);       // R5 wide poll gap
        chk(after_start >= 2, "R5", "repeated polls", after_start, 2);

        // R6 stuck busy
        stuck = 1;
        run(5'd3, 16'h0042, 1'b0, 16'h0, 0, 1, 1);
        stuck = 0; busy_cnt = 0;
        run(5'd3, 16'h0042, 1'b1, 16'h7777, 1, 1, 0);       // R6 recovery
        run(5'd3, 16'h0042, 1'b0, 16'h0, 1, 0, 0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a;
            a = ($urandom % 2) ? {12'hA50, 4'($urandom_range(0, 7))} : 16'($urandom);
            run(5'($urandom), a, 1'($urandom), 16'($urandom),
                int'($urandom_range(0, 6)), int'($urandom_range(0, 3)), 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog actual=hang expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule